// File: doc/BRIEF.md
# Two-Level FIFO Interrupt Status Collector

This block gathers interrupt event pulses from 32 FIFO channels. Each channel has a transmit direction and a receive direction. The 64 sources are split into 8 groups of 4 channels. Each group has an 8-bit sticky status register. An 8-bit summary register shows which groups hold a pending interrupt, and one interrupt line, gated by a global enable, tells the host that something is pending.

A host handles an interrupt in two steps. It first reads the summary register, which has no side effect. It then reads each group register that the summary flags. A group read returns the latched bits and clears them, so the matching summary bit falls once the group is empty. Reads use a single-cycle strobe with an address, and the read data is registered: it appears one cycle after the strobe and holds until the next strobe.

Top module: `fifo_irq_collector`

## Requirements
- R1: A synchronous active-high reset clears every group register. After reset the summary reads 0, `irq_out` is 0 and `rd_data` is 0.
- R2: An event pulse sets one group bit. A pulse on `tx_evt[c]` sets bit 2k of group n, and a pulse on `rx_evt[c]` sets bit 2k+1 of group n, where c = 4n+k. Group n is read at address 0x20+n.
- R3: A set group bit stays set, however many cycles pass, until its group register is read.
- R4: A strobed read of group n loads the group's value from before the clear into `rd_data` on the next cycle. The same read clears the group.
- R5: An event that arrives in the same cycle as the read-clear of its group takes priority. Its bit is set after the read, and the read data still shows the old value.
- R6: The summary register is at address 0x10. Its bit n is 1 exactly when any bit of group n is set.
- R7: A read of the summary register changes no group bit and no summary bit.
- R8: `irq_out` is 1 exactly when `irq_en` is 1 and at least one summary bit is set.
- R9: A strobed read at any address other than 0x10 or 0x20 to 0x27 returns 0 and clears nothing.
- R10: A read of group n leaves every other group register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_evt | input | 32 | Transmit-direction event pulse, one per channel |
| rx_evt | input | 32 | Receive-direction event pulse, one per channel |
| irq_en | input | 1 | Global enable for the combined interrupt |
| rd_stb | input | 1 | Single-cycle register read strobe |
| rd_addr | input | 8 | Register address, sampled with `rd_stb` |
| rd_data | output | 8 | Registered read data, valid the cycle after the strobe |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
The assertions assume three things about the inputs: reset is driven high from time zero, `rd_addr` matters only while `rd_stb` is high, and event inputs are sampled once per clock, so a pulse of any length counts as one event per cycle. The stimulus changes inputs only on the falling edge and holds reset for the first two cycles. Random events are kept sparse, so groups fill and empty many times over. Random reads cover every group address, the summary address and several unmapped addresses. Directed sequences place an event in the same cycle as the clear of its own group, read the summary twice in a row, and check that one group read leaves the other groups alone.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int NUM_GROUPS     = 8;
    localparam int CH_PER_GROUP   = 4;
    localparam int SRC_PER_GROUP  = 2 * CH_PER_GROUP;
    localparam int NUM_CHANNELS   = NUM_GROUPS * CH_PER_GROUP;
    localparam int ADDR_W         = 8;
    localparam int DATA_W         = SRC_PER_GROUP;
    localparam int GRP_IDX_W      = $clog2(NUM_GROUPS);

    localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 8'h10;
    localparam logic [ADDR_W-1:0] GROUP_BASE   = 8'h20;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_SUMMARY = 2'd1,
        SEL_GROUP   = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e              kind;
        logic [GRP_IDX_W-1:0]   grp;
    } rd_sel_t;

    typedef logic [SRC_PER_GROUP-1:0] grp_bits_t;

    function automatic rd_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        rd_sel_t s;
        logic [ADDR_W-1:0] off;
        s.kind = SEL_NONE;
        s.grp  = '0;
        off    = a - GROUP_BASE;
        if (a == SUMMARY_ADDR) begin
            s.kind = SEL_SUMMARY;
        end else if (a >= GROUP_BASE && off < ADDR_W'(NUM_GROUPS)) begin
            s.kind = SEL_GROUP;
            s.grp  = off[GRP_IDX_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_group_latch.sv
module irq_group_latch
    import fifo_irq_pkg::*;
#(
    parameter int CH = CH_PER_GROUP,
    localparam int SRC = 2 * CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CH-1:0]  tx_evt,
    input  logic [CH-1:0]  rx_evt,
    input  logic           clr,
    output logic [SRC-1:0] bits
);

    logic [SRC-1:0] evt_vec;
    logic [SRC-1:0] bits_q;

    // Interleave directions: even bit transmit, odd bit receive.
    for (genvar k = 0; k < CH; k++) begin : g_pack
        assign evt_vec[2*k]   = tx_evt[k];
        assign evt_vec[2*k+1] = rx_evt[k];
    end

    // New events override the read-clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (clr) begin
            bits_q <= evt_vec;
        end else begin
            bits_q <= bits_q | evt_vec;
        end
    end

    assign bits = bits_q;

    for (genvar i = 0; i < SRC; i++) begin : g_chk
        // R2 / R5: an event always leaves its bit set
        a_r2_event_sets : assert property (@(posedge clk) disable iff (rst)
            evt_vec[i] |=> bits_q[i]);
        // R3: set bits persist until cleared
        a_r3_sticky : assert property (@(posedge clk) disable iff (rst)
            (bits_q[i] && !clr) |=> bits_q[i]);
        // R4: a clear without a fresh event empties the bit
        a_r4_clear : assert property (@(posedge clk) disable iff (rst)
            (clr && !evt_vec[i]) |=> !bits_q[i]);
    end

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import fifo_irq_pkg::*;
#(
    parameter int GROUPS = NUM_GROUPS,
    parameter int SRC    = SRC_PER_GROUP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [GROUPS-1:0][SRC-1:0] grp_bits,
    input  logic                       irq_en,
    output logic [GROUPS-1:0]          summary,
    output logic                       irq_out
);

    for (genvar n = 0; n < GROUPS; n++) begin : g_or
        assign summary[n] = |grp_bits[n];
    end

    assign irq_out = irq_en & (|summary);

    // R8: the enable gates the combined line
    a_r8_gate : assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_out);
    // R6: the combined line needs a pending group
    a_r6_pending : assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (summary != '0));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import fifo_irq_pkg::*;
#(
    parameter int GROUPS = NUM_GROUPS,
    parameter int SRC    = SRC_PER_GROUP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_stb,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [GROUPS-1:0][SRC-1:0] grp_bits,
    input  logic [GROUPS-1:0]          summary,
    output logic [GROUPS-1:0]          clr_vec,
    output logic [DATA_W-1:0]          rd_data
);

    rd_sel_t           sel;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;

    assign sel = decode_addr(rd_addr);

    always_comb begin
        rd_next = '0;
        unique case (sel.kind)
            SEL_SUMMARY: rd_next = DATA_W'(summary);
            SEL_GROUP:   rd_next = DATA_W'(grp_bits[sel.grp]);
            default:     rd_next = '0;
        endcase
    end

    for (genvar n = 0; n < GROUPS; n++) begin : g_clr
        assign clr_vec[n] = rd_stb && (sel.kind == SEL_GROUP)
                            && (sel.grp == GRP_IDX_W'(n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_stb) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    // R10: at most one group cleared per read
    a_r10_one_clear : assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));
    // R9: unmapped reads return zero
    a_r9_unmapped_zero : assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sel.kind == SEL_NONE) |=> (rd_q == '0));
    // R9: unmapped reads clear nothing
    a_r9_unmapped_noclr : assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sel.kind == SEL_NONE) |-> (clr_vec == '0));

endmodule

// File: rtl/fifo_irq_collector.sv
module fifo_irq_collector
    import fifo_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CHANNELS-1:0] tx_evt,
    input  logic [NUM_CHANNELS-1:0] rx_evt,
    input  logic                    irq_en,
    input  logic                    rd_stb,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    irq_out
);

    logic [NUM_GROUPS-1:0][SRC_PER_GROUP-1:0] grp_bits;
    logic [NUM_GROUPS-1:0]                    summary;
    logic [NUM_GROUPS-1:0]                    clr_vec;

    for (genvar n = 0; n < NUM_GROUPS; n++) begin : g_grp
        irq_group_latch #(.CH(CH_PER_GROUP)) u_latch (
            .clk    (clk),
            .rst    (rst),
            .tx_evt (tx_evt[n*CH_PER_GROUP +: CH_PER_GROUP]),
            .rx_evt (rx_evt[n*CH_PER_GROUP +: CH_PER_GROUP]),
            .clr    (clr_vec[n]),
            .bits   (grp_bits[n])
        );
    end

    irq_summary #(.GROUPS(NUM_GROUPS), .SRC(SRC_PER_GROUP)) u_summary (
        .clk      (clk),
        .rst      (rst),
        .grp_bits (grp_bits),
        .irq_en   (irq_en),
        .summary  (summary),
        .irq_out  (irq_out)
    );

    irq_reg_port #(.GROUPS(NUM_GROUPS), .SRC(SRC_PER_GROUP)) u_port (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .grp_bits (grp_bits),
        .summary  (summary),
        .clr_vec  (clr_vec),
        .rd_data  (rd_data)
    );

    // R1: reset empties all state
    a_r1_reset : assert property (@(posedge clk)
        rst |=> (summary == '0 && rd_data == '0 && !irq_out));
    // R7: reading the summary never drops a pending group
    a_r7_no_side_effect : assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == SUMMARY_ADDR)
            |=> ((summary & $past(summary)) == $past(summary)));

endmodule

// File: tb/fifo_irq_collector_test.sv
module fifo_irq_collector_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_evt = '0;
    logic [31:0] rx_evt = '0;
    logic        irq_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;

    fifo_irq_collector uut (
        .clk(clk), .rst(rst), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .irq_en(irq_en), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [7:0] pack_grp(input logic [31:0] tx, input logic [31:0] rx, input int n);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) begin
            v[2*k]   = tx[4*n+k];
            v[2*k+1] = rx[4*n+k];
        end
        return v;
    endfunction

    function automatic logic [7:0] summary_model();
        logic [7:0] s;
        for (int n = 0; n < 8; n++) s[n] = |model[n];
        return s;
    endfunction

    function automatic logic [7:0] read_model(input logic [7:0] a);
        if (a == 8'h10) return summary_model();
        if (a >= 8'h20 && a <= 8'h27) return model[a - 8'h20];
        return 8'h00;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [31:0] tx, input logic [31:0] rx, input logic stb,
                       input logic [7:0] addr, input logic en, input string req);
        logic [7:0] pre;
        logic       is_grp;
        @(negedge clk);
        tx_evt = tx; rx_evt = rx; rd_stb = stb; rd_addr = addr; irq_en = en;
        pre = read_model(addr);
        is_grp = stb && addr >= 8'h20 && addr <= 8'h27;
        @(posedge clk);
        #1;
        for (int n = 0; n < 8; n++) begin
            if (is_grp && (addr - 8'h20) == n) model[n] = 8'h00;
            model[n] = model[n] | pack_grp(tx, rx, n);
        end
        if (stb) chk(rd_data == pre, req, {24'h0, rd_data}, {24'h0, pre});
        chk(irq_out == (en && (summary_model() != 0)), "R8", {31'h0, irq_out},
            {31'h0, en && (summary_model() != 0)});
    endtask

    task automatic rd(input logic [7:0] addr, input string req);
        cyc('0, '0, 1'b1, addr, 1'b1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 8; n++) model[n] = 8'h00;
        irq_en = 1'b1;
        tx_evt = '1;
        rx_evt = '1;
        repeat (2) @(posedge clk);
        #1;
        // R1: events during reset are dropped; outputs are zero
        chk(rd_data == 8'h00, "R1", {24'h0, rd_data}, 32'h0);
        chk(irq_out == 1'b0, "R1", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0; tx_evt = '0; rx_evt = '0;
        rd(8'h10, "R1");
        rd(8'h27, "R1");

        // R2: receive event on channel 13 -> group 3 bit 3
        cyc('0, 32'h0000_2000, 1'b0, 8'h00, 1'b1, "R2");
        rd(8'h10, "R6");
        chk(rd_data == 8'h08, "R6", {24'h0, rd_data}, 32'h08);
        // R3: hold over idle cycles
        for (int i = 0; i < 20; i++) cyc('0, '0, 1'b0, 8'h00, 1'b1, "R3");
        rd(8'h23, "R2");
        chk(rd_data == 8'h08, "R2", {24'h0, rd_data}, 32'h08);
        rd(8'h23, "R4");
        chk(rd_data == 8'h00, "R4", {24'h0, rd_data}, 32'h00);

        // R5: event on cleared group in the clear cycle
        cyc(32'h0000_0001, '0, 1'b0, 8'h00, 1'b1, "R2");
        cyc('0, 32'h0000_0002, 1'b1, 8'h20, 1'b1, "R5");
        chk(rd_data == 8'h01, "R5", {24'h0, rd_data}, 32'h01);
        rd(8'h20, "R5");
        chk(rd_data == 8'h08, "R5", {24'h0, rd_data}, 32'h08);
        rd(8'h20, "R4");

        // R7 / R10: groups 2 and 5 pending
        cyc(32'h0010_0100, 32'h0000_0000, 1'b0, 8'h00, 1'b0, "R8");
        rd(8'h10, "R7");
        chk(rd_data == 8'h24, "R7", {24'h0, rd_data}, 32'h24);
        rd(8'h10, "R7");
        chk(rd_data == 8'h24, "R7", {24'h0, rd_data}, 32'h24);
        rd(8'h22, "R10");
        rd(8'h25, "R10");
        chk(rd_data == 8'h01, "R10", {24'h0, rd_data}, 32'h01);
        // R9: unmapped reads
        cyc(32'h8000_0000, '0, 1'b0, 8'h00, 1'b1, "R2");
        rd(8'h11, "R9");
        rd(8'h28, "R9");
        rd(8'hFF, "R9");
        rd(8'h27, "R9");
        chk(rd_data == 8'h40, "R9", {24'h0, rd_data}, 32'h40);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] tx, rx;
            logic [7:0]  a;
            int          r;
            string       req;
            tx = $urandom & $urandom & $urandom & $urandom;
            rx = $urandom & $urandom & $urandom & $urandom;
            r  = int'($urandom % 12);
            if (r < 8) begin a = 8'h20 + 8'(r); req = "R4"; end
            else if (r < 10) begin a = 8'h10; req = "R6"; end
            else begin
                a = 8'($urandom);
                if (a == 8'h10 || (a >= 8'h20 && a <= 8'h27)) a = 8'h3C;
                req = "R9";
            end
            cyc(tx, rx, ($urandom % 3) == 0, a, ($urandom % 8) != 0, req);
        end

        // Drain and confirm empty
        for (int n = 0; n < 8; n++) rd(8'h20 + 8'(n), "R4");
        rd(8'h10, "R6");
        chk(rd_data == 8'h00, "R6", {24'h0, rd_data}, 32'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule